// File: doc/BRIEF.md
# Serial-Programmed Switch Enable Controller

This block controls a bank of five switch groups that route analog signals: three luma/chroma pairs (Y0/C0, Y1/C1, Y2/C2) and two RGB-plus-blanking groups. It is a receive-only two-wire (I2C) slave. A master addresses it with a write request and then sends one or more bytes. The low five bits of each complete byte become the switch enables right away. A strap pin, `mode_direct`, turns the serial receiver off. When it is high, the select pin and the two bus pins form a 3-bit code that drives the enables combinationally.

In serial mode the bus lines are sampled by a fast system clock. Each line passes through a two-flop synchronizer and a glitch filter. The controller then detects start and stop conditions and the SCL edges. The receiver state machine has six states:

- `ST_IDLE`: waits for a start.
- `ST_ADDR`: shifts in the address byte.
- `ST_ADDR_ACK`: drives the acknowledge for the address.
- `ST_DATA`: shifts in a data byte.
- `ST_DATA_ACK`: drives the acknowledge and applies the byte.
- `ST_SKIP`: the byte was not for this device, so it waits for the next start or stop.

The transitions are:

- A start leads to `ST_ADDR` from any state.
- A stop leads to `ST_IDLE` from any state.
- The eighth falling SCL edge in `ST_ADDR` leads to `ST_ADDR_ACK` on a match, or to `ST_SKIP` otherwise.
- The next falling edge leads from `ST_ADDR_ACK` to `ST_DATA`.
- The eighth falling edge in `ST_DATA` leads to `ST_DATA_ACK`.
- The next falling edge leads from `ST_DATA_ACK` back to `ST_DATA`.
- Direct mode forces `ST_IDLE`.

Top module: `swsel_ctrl`

## Requirements
- R1: The device answers the 7-bit address 1,1,0,1,1,0,A0, sent MSB first, where A0 is the inverse of `sel`. The address byte is therefore 0xD8 when `sel`=1 and 0xDA when `sel`=0. Any other address gets no acknowledge, and the data bytes after it are ignored.
- R2: An address byte whose last bit (read/write) is 1 gets no acknowledge and leaves `sw_en` unchanged.
- R3: For an acknowledge, `sda_oe` rises after the falling SCL edge that ends bit 8 and before the ninth rising edge. It falls after the ninth falling edge. At all other times it stays low.
- R4: Data arrives MSB first. `sw_en[0]` is bit 0 (Y0/C0), `sw_en[1]` is bit 1 (Y1/C1), `sw_en[2]` is bit 2 (Y2/C2), `sw_en[3]` is bit 3 (group 1 RGB+blanking) and `sw_en[4]` is bit 4 (group 2). Bits 7..5 have no effect.
- R5: Each further data byte in the same transfer overwrites `sw_en` when it completes.
- R6: A stop partway through a byte leaves `sw_en` at the last complete byte. The value is held between transfers and across a stay in direct mode.
- R7: Reset clears `sw_en` to 0 and releases `sda_oe`.
- R8: When `mode_direct`=1, the code {`sel`,`sda_in`,`scl_in`} sets `sw_en` combinationally as follows:

  | Code | `sw_en` |
  |------|---------|
  | 000 | 00000 |
  | 001 | 00001 |
  | 010 | 00010 |
  | 011 | 00100 |
  | 100 | 01000 |
  | 101 | 10000 |
  | 110 | 01010 |
  | 111 | 10100 |

- R9: A start in the middle of a byte restarts address reception from bit 0.
- R10: A pulse on SCL shorter than `FILT_LEN` system clocks is ignored.
- R11: When `mode_direct`=1, the receiver returns to idle and `sda_oe` stays low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Active-low power-on reset |
| mode_direct | input | 1 | 1 = direct 3-bit decode, 0 = serial receiver |
| sel | input | 1 | Address LSB select (serial mode) or code bit 2 (direct mode) |
| scl_in | input | 1 | Serial clock line, or code bit 0 |
| sda_in | input | 1 | Serial data line as seen on the wire, or code bit 1 |
| sda_oe | output | 1 | Active-high enable that pulls SDA low for the acknowledge |
| sw_en | output | 5 | Switch group enables, 1 = on |

## Verification
A wrong receiver state shows at the ports within one bus bit. A miscounted or misrouted state makes `sda_oe` appear in the wrong SCL phase, or not appear during the ninth pulse. It also makes `sw_en` take a shifted or stale byte, which can be seen once the stop has settled. Filter or edge-detection faults show as bytes shifted by one bit, or as missing acknowledges after a glitch. Direct-mode faults change `sw_en` within a cycle of the pin code changing.

// File: rtl/swsel_pkg.sv
package swsel_pkg;
    localparam int SW_W = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_DATA,
        ST_DATA_ACK,
        ST_SKIP
    } rx_state_t;
endpackage

// File: rtl/swsel_deglitch.sv
module swsel_deglitch #(
    parameter int   FILT_LEN = 4,
    parameter logic RST_VAL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic clean
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic          s1, s2;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1    <= RST_VAL;
            s2    <= RST_VAL;
            clean <= RST_VAL;
            cnt   <= '0;
        end else begin
            s1 <= raw;
            s2 <= s1;
            if (s2 == clean) begin
                cnt <= '0;
            end else if (cnt == CW'(FILT_LEN - 1)) begin
                clean <= s2;
                cnt   <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // R10: the filtered level only moves to a synchronized level held long enough
    assert_filter_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(clean) |-> (clean == $past(s2)) && ($past(cnt) == CW'(FILT_LEN - 1)));
endmodule

// File: rtl/swsel_direct_map.sv
module swsel_direct_map (
    input  logic [2:0] code,
    output logic [4:0] en
);
    always_comb begin
        unique case (code)
            3'b000:  en = 5'b00000;
            3'b001:  en = 5'b00001;
            3'b010:  en = 5'b00010;
            3'b011:  en = 5'b00100;
            3'b100:  en = 5'b01000;
            3'b101:  en = 5'b10000;
            3'b110:  en = 5'b01010;
            3'b111:  en = 5'b10100;
            default: en = 5'b00000;
        endcase
    end
endmodule

// File: rtl/swsel_rx_fsm.sv
module swsel_rx_fsm
    import swsel_pkg::*;
#(
    parameter logic [5:0] ADDR_HI = 6'b110110
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            sel,
    input  logic            scl,
    input  logic            sda,
    output logic            sda_oe,
    output logic [SW_W-1:0] sw_q
);
    rx_state_t  state, nxt;
    logic       scl_p, sda_p;
    logic [3:0] bit_cnt;
    logic [7:0] shreg;

    logic scl_rise, scl_fall, start_ev, stop_ev, byte_done, addr_hit, clr_cnt;

    assign scl_rise  = scl & ~scl_p;
    assign scl_fall  = ~scl & scl_p;
    assign start_ev  = scl & scl_p & sda_p & ~sda;
    assign stop_ev   = scl & scl_p & ~sda_p & sda;
    assign byte_done = (bit_cnt == 4'd8);
    assign addr_hit  = (shreg[7:1] == {ADDR_HI, ~sel}) && !shreg[0];
    assign clr_cnt   = start_ev |
                       (scl_fall & ((state == ST_ADDR_ACK) | (state == ST_DATA_ACK)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl;
            sda_p <= sda;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        if (!enable) begin
            nxt = ST_IDLE;
        end else if (start_ev) begin
            nxt = ST_ADDR;
        end else if (stop_ev) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_SKIP:     nxt = ST_SKIP;
                ST_ADDR:     if (scl_fall && byte_done) nxt = addr_hit ? ST_ADDR_ACK : ST_SKIP;
                ST_ADDR_ACK: if (scl_fall) nxt = ST_DATA;
                ST_DATA:     if (scl_fall && byte_done) nxt = ST_DATA_ACK;
                ST_DATA_ACK: if (scl_fall) nxt = ST_DATA;
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_oe = (state == ST_ADDR_ACK) || (state == ST_DATA_ACK);
    end

    // shift path and switch register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            sw_q    <= '0;
        end else begin
            if (clr_cnt) begin
                bit_cnt <= '0;
            end else if (scl_rise && !byte_done &&
                         ((state == ST_ADDR) || (state == ST_DATA))) begin
                shreg   <= {shreg[6:0], sda};
                bit_cnt <= bit_cnt + 1'b1;
            end
            if (enable && !start_ev && !stop_ev &&
                (state == ST_DATA) && scl_fall && byte_done) begin
                sw_q <= shreg[SW_W-1:0];
            end
        end
    end

    // R3: acknowledge is raised only while SCL is low
    assert_ack_low_phase_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl);

    // R3: acknowledge is dropped by a falling SCL edge unless the bus was aborted
    assert_ack_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sda_oe) && $past(enable) && !$past(start_ev) && !$past(stop_ev)) |-> !scl);

    // R2: only a write request reaches the address acknowledge
    assert_write_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR_ACK) |-> (shreg[0] == 1'b0));

    // R6: the switch register changes only when a data byte completes
    assert_update_on_byte_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sw_q) |-> ($past(state) == ST_DATA) && ($past(bit_cnt) == 4'd8));

    // R9: a start always restarts address reception at bit 0
    assert_start_restarts_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (start_ev && enable) |=> (state == ST_ADDR) && (bit_cnt == 4'd0));

    // R11: direct mode parks the receiver
    assert_direct_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state == ST_IDLE));
endmodule

// File: rtl/swsel_ctrl.sv
module swsel_ctrl
    import swsel_pkg::*;
#(
    parameter int         FILT_LEN = 4,
    parameter logic [5:0] ADDR_HI  = 6'b110110
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_direct,
    input  logic            sel,
    input  logic            scl_in,
    input  logic            sda_in,
    output logic            sda_oe,
    output logic [SW_W-1:0] sw_en
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw_l, clean_l;
    logic               fsm_oe;
    logic [SW_W-1:0]    sw_q, dir_en;

    assign raw_l = {sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        swsel_deglitch #(.FILT_LEN(FILT_LEN), .RST_VAL(1'b1)) i_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .raw   (raw_l[g]),
            .clean (clean_l[g])
        );
    end

    swsel_rx_fsm #(.ADDR_HI(ADDR_HI)) i_rx (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (~mode_direct),
        .sel    (sel),
        .scl    (clean_l[0]),
        .sda    (clean_l[1]),
        .sda_oe (fsm_oe),
        .sw_q   (sw_q)
    );

    swsel_direct_map i_dmap (
        .code ({sel, sda_in, scl_in}),
        .en   (dir_en)
    );

    assign sda_oe = fsm_oe & ~mode_direct;
    assign sw_en  = mode_direct ? dir_en : sw_q;

    // R8: the direct code never turns on both RGB groups or more than two groups
    assert_direct_limit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        mode_direct |-> ($countones(sw_en) <= 2) && !(sw_en[3] && sw_en[4]));
endmodule

// File: tb/test_swsel_ctrl.sv
module test_swsel_ctrl;
    localparam int H = 40;
    localparam int Q = 20;
    localparam int NV = 8;

    // {sel, address byte, data byte, expected ack, expected sw_en}
    localparam logic [22:0] VEC [NV] = '{
        {1'b1, 8'hD8, 8'h15, 1'b1, 5'h15},
        {1'b1, 8'hD8, 8'hEA, 1'b1, 5'h0A},
        {1'b1, 8'hDA, 8'h3F, 1'b0, 5'h0A},
        {1'b1, 8'hD9, 8'h3F, 1'b0, 5'h0A},
        {1'b0, 8'hDA, 8'h1F, 1'b1, 5'h1F},
        {1'b0, 8'hD8, 8'h00, 1'b0, 5'h1F},
        {1'b0, 8'hDB, 8'h00, 1'b0, 5'h1F},
        {1'b0, 8'hDA, 8'h04, 1'b1, 5'h04}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_direct = 1'b0;
    logic       sel = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_oe;
    logic [4:0] sw_en;
    logic       sda_line;
    int         checks = 0;
    int         fails = 0;
    bit         done = 1'b0;

    assign sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    swsel_ctrl i_swsel_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .mode_direct (mode_direct),
        .sel         (sel),
        .scl_in      (scl_m),
        .sda_in      (sda_line),
        .sda_oe      (sda_oe),
        .sw_en       (sw_en)
    );

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b0; wait_cyc(H);
        scl_m = 1'b0; wait_cyc(Q);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wait_cyc(Q);
        scl_m = 1'b1; wait_cyc(H);
        sda_m = 1'b1; wait_cyc(H);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        sda_m = b; wait_cyc(Q);
        if (glitch) begin
            scl_m = 1'b1; wait_cyc(1);
            scl_m = 1'b0; wait_cyc(Q);
        end
        scl_m = 1'b1; wait_cyc(H);
        scl_m = 1'b0; wait_cyc(Q);
    endtask

    // returns ack seen before and during the ninth pulse, and level after it
    task automatic send_byte(input logic [7:0] b, input bit glitch,
                             output logic ack, output logic oe_mid8, output logic oe_after);
        logic pre;
        oe_mid8 = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wait_cyc(Q);
            if (glitch && i == 3) begin
                scl_m = 1'b1; wait_cyc(1);
                scl_m = 1'b0; wait_cyc(Q);
            end
            scl_m = 1'b1; wait_cyc(H / 2);
            if (i == 0) oe_mid8 = sda_oe;
            wait_cyc(H / 2);
            scl_m = 1'b0; wait_cyc(Q);
        end
        sda_m = 1'b1; wait_cyc(Q);
        pre = sda_oe;
        scl_m = 1'b1; wait_cyc(H / 2);
        ack = pre & sda_oe;
        wait_cyc(H / 2);
        scl_m = 1'b0; wait_cyc(Q);
        oe_after = sda_oe;
    endtask

    function automatic logic [4:0] direct_exp(input logic [2:0] c);
        case (c)
            3'd0: return 5'h00;
            3'd1: return 5'h01;
            3'd2: return 5'h02;
            3'd3: return 5'h04;
            3'd4: return 5'h08;
            3'd5: return 5'h10;
            3'd6: return 5'h0A;
            default: return 5'h14;
        endcase
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic a, m8, af;
        wait_cyc(10);
        // R7: reset state
        chk("R7 sw_en in reset", sw_en, 0);
        chk("R7 sda_oe in reset", sda_oe, 0);
        rst_n = 1'b1;
        wait_cyc(10);
        chk("R7 sw_en after reset", sw_en, 0);

        // table walk: R1, R2, R3, R4
        for (int v = 0; v < NV; v++) begin
            sel = VEC[v][22];
            bus_start();
            send_byte(VEC[v][21:14], 1'b0, a, m8, af);
            chk($sformatf("R1 R2 addr ack vec %0d", v), a, VEC[v][5]);
            chk($sformatf("R3 no ack during bit8 vec %0d", v), m8, 0);
            chk($sformatf("R3 ack released vec %0d", v), af, 0);
            send_byte(VEC[v][13:6], 1'b0, a, m8, af);
            chk($sformatf("R1 data ack vec %0d", v), a, VEC[v][5]);
            chk($sformatf("R3 data ack released vec %0d", v), af, 0);
            bus_stop();
            chk($sformatf("R4 sw_en vec %0d", v), sw_en, VEC[v][4:0]);
        end

        // R5: several bytes in one transfer
        sel = 1'b0;
        bus_start();
        send_byte(8'hDA, 1'b0, a, m8, af);
        send_byte(8'h01, 1'b0, a, m8, af);
        chk("R5 first byte applied", sw_en, 5'h01);
        send_byte(8'hF2, 1'b0, a, m8, af);
        chk("R5 second byte ack", a, 1);
        chk("R5 second byte applied", sw_en, 5'h12);
        bus_stop();
        chk("R5 after stop", sw_en, 5'h12);

        // R6: stop partway through a byte
        bus_start();
        send_byte(8'hDA, 1'b0, a, m8, af);
        send_byte(8'h03, 1'b0, a, m8, af);
        for (int i = 0; i < 4; i++) send_bit(1'b1, 1'b0);
        bus_stop();
        chk("R6 partial byte dropped", sw_en, 5'h03);
        wait_cyc(200);
        chk("R6 value held idle", sw_en, 5'h03);

        // R9: repeated start in the middle of the address byte
        bus_start();
        send_bit(1'b1, 1'b0);
        send_bit(1'b1, 1'b0);
        send_bit(1'b0, 1'b0);
        bus_start();
        send_byte(8'hDA, 1'b0, a, m8, af);
        chk("R9 address after restart acked", a, 1);
        send_byte(8'h08, 1'b0, a, m8, af);
        bus_stop();
        chk("R9 data after restart", sw_en, 5'h08);

        // R10: short SCL glitch inside a data byte
        bus_start();
        send_byte(8'hDA, 1'b0, a, m8, af);
        send_byte(8'h11, 1'b1, a, m8, af);
        chk("R10 ack despite glitch", a, 1);
        bus_stop();
        chk("R10 byte intact despite glitch", sw_en, 5'h11);

        // R8, R11: direct decode
        mode_direct = 1'b1;
        for (int c = 0; c < 8; c++) begin
            sel   = c[2];
            sda_m = c[1];
            scl_m = c[0];
            wait_cyc(3);
            chk($sformatf("R8 direct code %0d", c), sw_en, direct_exp(3'(c)));
            chk($sformatf("R11 sda released code %0d", c), sda_oe, 0);
        end
        sel = 1'b0; sda_m = 1'b1; scl_m = 1'b1;
        wait_cyc(3);
        mode_direct = 1'b0;
        wait_cyc(20);
        chk("R6 serial value kept across direct mode", sw_en, 5'h11);

        // serial path still works after direct mode
        bus_start();
        send_byte(8'hDA, 1'b0, a, m8, af);
        send_byte(8'hE2, 1'b0, a, m8, af);
        bus_stop();
        chk("R4 upper bits ignored after direct mode", sw_en, 5'h02);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule